// File: doc/BRIEF.md
# Flow-Through Burst SRAM With Zero Turnaround

This block is a synthesizable model of a synchronous single-port SRAM in which reads and writes may alternate on every clock with no idle cycle between them. A read presents its word during the same cycle that its address was registered (flow-through). A write registers its address and control at one edge and takes its data word at the following edge, so data always trails its address by one clock. The word is 18 bits wide and is split into two 9-bit lanes, each holding 8 data bits and a parity bit. The depth is set by a parameter.

A 2-bit burst sequencer steps through up to four words from one loaded address, in either linear or interleaved order. A clock-enable input freezes the whole block for as many cycles as needed. The data bus is split into a data-in port, a data-out port and a drive-enable port. A bus wrapper can combine them into a bidirectional pin.

Top module: `flow_sram`

## Requirements
- R1: When an enabled edge has `advLd` low, the block starts a new access only if `ce1N` is low, `ce2` is high and `ce3N` is low at that edge. `weN` high then starts a read and `weN` low starts a write. Any other chip-enable pattern deselects the block.
- R2: A write registers its address at edge N and its data from `dIn` at the next enabled edge N+1. A new read, write or deselect may be issued at edge N+1.
- R3: A read drives the addressed word on `dOut` in the cycle that starts at its address edge. `dOe` is high in that cycle only while `oeN` is low, and `oeN` acts without a clock.
- R4: `dOe` is low during the data cycle of every write, including a write with no lane selected. It is also low while the block is deselected and after reset, whatever the level of `oeN`.
- R5: An enabled edge with `advLd` high during an access advances the burst. On that edge the chip enables and `weN` are ignored, and the read or write type chosen at the load is kept.
- R6: With `modeSel` low the low two address bits follow (start + k) mod 4. With `modeSel` high they follow start XOR k, where k is the beat count. The upper address bits stay fixed, and the sequence wraps after four beats.
- R7: While `cenN` is high the edge is ignored. All state is held, including a write still waiting for its data, and no array write happens. A waiting write takes its data at the next enabled edge.
- R8: `bwN[0]` (active low) gates lane A, which is `dIn[8:0]`. `bwN[1]` gates lane B, which is `dIn[17:9]`. Both are sampled at the edge that carries the write's address or burst step. Any combination is allowed, and a lane that is not selected keeps its contents.
- R9: After reset the block is deselected. An enabled edge with `advLd` high while deselected keeps it deselected, so only `advLd` low can start a new access.
- R10: A read of the address written in the cycle before returns the newly written lanes merged with the lanes that were left untouched.

Ports, in port-list order:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| cenN | input | 1 | Clock enable, active low |
| advLd | input | 1 | High advances the burst, low loads a new address |
| ce1N | input | 1 | Chip enable, active low |
| ce2 | input | 1 | Chip enable, active high |
| ce3N | input | 1 | Chip enable, active low |
| weN | input | 1 | Write enable, active low |
| bwN | input | 2 | Lane write selects, active low |
| modeSel | input | 1 | Burst order strap: 0 linear, 1 interleaved |
| oeN | input | 1 | Output enable, active low, not clocked |
| addr | input | ADDR_W | Word address |
| dIn | input | 18 | Write data |
| dOut | output | 18 | Read data |
| dOe | output | 1 | Output drive enable |

## Verification
The burst counter, the latched access type and the waiting-write register are all internal state, so an error in any of them shows only one or two cycles later. A wrong burst counter or address base returns another location's word on `dOut` in the very beat it affects. A lost access type shows as `dOe` rising during a write beat, or dropping during a read beat. A waiting write that is dropped or applied twice under a stall shows at the first read of that address, which is the cycle after the data edge when the read follows back-to-back. The directed tests therefore read every written location again at once and again later, so that both the forwarding path and the array path are covered.

// File: rtl/fts_pkg.sv
`timescale 1ns/1ps
package fts_pkg;
  localparam int NUM_LANES = 2;
  localparam int LANE_W    = 9;
  localparam int WORD_W    = NUM_LANES * LANE_W;

  // Strobes from the control FSM to the datapath for the current cycle
  typedef struct packed {
    logic                 rd;
    logic                 wr;
    logic [NUM_LANES-1:0] bwN;
  } op_t;
endpackage

// File: rtl/fts_ctrl.sv
`timescale 1ns/1ps
module fts_ctrl
  import fts_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cenN,
  input  logic                 advLd,
  input  logic                 ce1N,
  input  logic                 ce2,
  input  logic                 ce3N,
  input  logic                 weN,
  input  logic [NUM_LANES-1:0] bwN,
  input  logic                 modeSel,
  input  logic [ADDR_W-1:0]    addr,
  output op_t                  opQ,
  output logic [ADDR_W-1:0]    curAddr
);
  logic [ADDR_W-1:0] baseAddr;
  logic [1:0]        beat;
  logic [1:0]        lowBits;
  logic              selHit;
  logic              busy;

  assign selHit = !ce1N && ce2 && !ce3N;
  assign busy   = opQ.rd || opQ.wr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opQ      <= '0;
      baseAddr <= '0;
      beat     <= '0;
    end else if (!cenN) begin
      if (!advLd) begin
        baseAddr <= addr;
        beat     <= 2'd0;
        opQ.rd   <= selHit && weN;
        opQ.wr   <= selHit && !weN;
        opQ.bwN  <= bwN;
      end else if (busy) begin
        beat    <= beat + 2'd1;
        opQ.bwN <= bwN;
      end
    end
  end

  always_comb begin
    if (modeSel) lowBits = baseAddr[1:0] ^ beat;
    else         lowBits = baseAddr[1:0] + beat;
    curAddr = {baseAddr[ADDR_W-1:2], lowBits};
  end

  // R1
  no_dual_op_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(opQ.rd && opQ.wr));
  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    cenN |=> ($stable(curAddr) && $stable(opQ)));
  // R5
  burst_type_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!cenN && advLd && busy) |=> ($stable(opQ.rd) && $stable(opQ.wr)));
  // R9
  desel_stay_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!cenN && advLd && !busy) |=> (!opQ.rd && !opQ.wr));
  // R6
  burst_page_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!cenN && advLd) |=> $stable(curAddr[ADDR_W-1:2]));
endmodule

// File: rtl/fts_datapath.sv
`timescale 1ns/1ps
module fts_datapath
  import fts_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cenN,
  input  op_t               opQ,
  input  logic [ADDR_W-1:0] curAddr,
  input  logic [WORD_W-1:0] dIn,
  input  logic              oeN,
  output logic [WORD_W-1:0] dOut,
  output logic              dOe
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [WORD_W-1:0]    mem [DEPTH];
  logic                 pendValid;
  logic [ADDR_W-1:0]    pendAddr;
  logic [WORD_W-1:0]    pendData;
  logic [NUM_LANES-1:0] pendBwN;
  logic [WORD_W-1:0]    arrWord;
  logic                 fwdHit;

  // Write data is parked one enabled edge, then retired into the array
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendValid <= 1'b0;
      pendAddr  <= '0;
      pendData  <= '0;
      pendBwN   <= '1;
    end else if (!cenN) begin
      pendValid <= opQ.wr;
      pendAddr  <= curAddr;
      pendData  <= dIn;
      pendBwN   <= opQ.bwN;
    end
  end

  always_ff @(posedge clk) begin
    if (!cenN && pendValid) begin
      for (int l = 0; l < NUM_LANES; l++) begin
        if (!pendBwN[l]) mem[pendAddr][l*LANE_W +: LANE_W] <= pendData[l*LANE_W +: LANE_W];
      end
    end
  end

  assign arrWord = mem[curAddr];
  assign fwdHit  = pendValid && (pendAddr == curAddr);

  for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
    assign dOut[l*LANE_W +: LANE_W] = (fwdHit && !pendBwN[l]) ?
      pendData[l*LANE_W +: LANE_W] : arrWord[l*LANE_W +: LANE_W];
  end

  assign dOe = opQ.rd && !oeN;

  // R4
  write_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    opQ.wr |-> !dOe);
  // R7
  pend_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    cenN |=> ($stable(pendValid) && $stable(pendAddr) && $stable(pendData)));
  // R2
  pend_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!cenN && opQ.wr) |=> pendValid);
endmodule

// File: rtl/flow_sram.sv
`timescale 1ns/1ps
module flow_sram
  import fts_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cenN,
  input  logic              advLd,
  input  logic              ce1N,
  input  logic              ce2,
  input  logic              ce3N,
  input  logic              weN,
  input  logic [1:0]        bwN,
  input  logic              modeSel,
  input  logic              oeN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [17:0]       dIn,
  output logic [17:0]       dOut,
  output logic              dOe
);
  op_t               opQ;
  logic [ADDR_W-1:0] curAddr;

  fts_ctrl #(.ADDR_W(ADDR_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .cenN(cenN), .advLd(advLd),
    .ce1N(ce1N), .ce2(ce2), .ce3N(ce3N), .weN(weN), .bwN(bwN),
    .modeSel(modeSel), .addr(addr), .opQ(opQ), .curAddr(curAddr)
  );

  fts_datapath #(.ADDR_W(ADDR_W)) i_dp (
    .clk(clk), .rstN(rstN), .cenN(cenN), .opQ(opQ), .curAddr(curAddr),
    .dIn(dIn), .oeN(oeN), .dOut(dOut), .dOe(dOe)
  );
endmodule

// File: tb/test_flow_sram.sv
`timescale 1ns/1ps
module test_flow_sram;
  localparam int AW = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cenN = 1'b1, advLd = 1'b0, ce1N = 1'b1, ce2 = 1'b0, ce3N = 1'b1, weN = 1'b1;
  logic [1:0] bwN = 2'b11;
  logic modeSel = 1'b0, oeN = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [17:0] dIn = '0;
  logic [17:0] dOut;
  logic dOe;

  int errors = 0;
  int checks = 0;
  logic [17:0] refMem [64];

  always #2 clk = ~clk;

  flow_sram #(.ADDR_W(AW)) i_flow_sram (
    .clk(clk), .rstN(rstN), .cenN(cenN), .advLd(advLd), .ce1N(ce1N), .ce2(ce2),
    .ce3N(ce3N), .weN(weN), .bwN(bwN), .modeSel(modeSel), .oeN(oeN),
    .addr(addr), .dIn(dIn), .dOut(dOut), .dOe(dOe)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input logic [17:0] act, input logic [17:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [17:0] mrg(input logic [17:0] old, input logic [17:0] nw,
                                      input logic [1:0] bw);
    logic [17:0] r = old;
    if (!bw[0]) r[8:0]  = nw[8:0];
    if (!bw[1]) r[17:9] = nw[17:9];
    return r;
  endfunction

  task automatic doRead(input logic [AW-1:0] a);
    cenN = 0; advLd = 0; ce1N = 0; ce2 = 1; ce3N = 0; weN = 1; bwN = 2'b11; addr = a;
  endtask
  task automatic doWrite(input logic [AW-1:0] a, input logic [1:0] bw);
    cenN = 0; advLd = 0; ce1N = 0; ce2 = 1; ce3N = 0; weN = 0; bwN = bw; addr = a;
  endtask
  // Burst step with deliberately hostile chip enables, write enable and address
  task automatic doAdv(input logic [1:0] bw);
    cenN = 0; advLd = 1; ce1N = 1; ce2 = 0; ce3N = 1; weN = ~weN; bwN = bw; addr = ~addr;
  endtask
  task automatic doDesel();
    cenN = 0; advLd = 0; ce1N = 1; ce2 = 1; ce3N = 0;
  endtask

  task automatic tReset();
    oeN = 0;
    chk("R9 reset deselected dOe", {17'd0, dOe}, 18'd0);
    doRead(5); ce2 = 0; step();
    chk("R1 ce2 low no access", {17'd0, dOe}, 18'd0);
    doRead(5); ce3N = 1; step();
    chk("R1 ce3N high no access", {17'd0, dOe}, 18'd0);
  endtask

  task automatic tSingle();
    doWrite(5, 2'b00); step();
    chk("R4 write data cycle dOe", {17'd0, dOe}, 18'd0);
    dIn = 18'h2A5C3; doRead(5); step();
    refMem[5] = 18'h2A5C3;
    chk("R10 read after write data", dOut, refMem[5]);
    chk("R3 read dOe", {17'd0, dOe}, 18'd1);
    oeN = 1; #1;
    chk("R3 oeN high masks", {17'd0, dOe}, 18'd0);
    oeN = 0; #0.5;
    doDesel(); step();
    chk("R4 deselected dOe", {17'd0, dOe}, 18'd0);
  endtask

  task automatic tBytes();
    doWrite(5, 2'b10); step();
    dIn = 18'h15A3C; doWrite(5, 2'b11); step();
    refMem[5] = mrg(refMem[5], 18'h15A3C, 2'b10);
    chk("R4 no-lane write data cycle dOe", {17'd0, dOe}, 18'd0);
    dIn = 18'h3FFFF; doRead(5); step();
    chk("R8 lane A only then no-lane", dOut, refMem[5]);
    doWrite(5, 2'b01); step();
    dIn = 18'h0F0F0; doRead(5); step();
    refMem[5] = mrg(refMem[5], 18'h0F0F0, 2'b01);
    chk("R8 lane B forwarded", dOut, refMem[5]);
    doDesel(); step();
    doRead(5); step();
    chk("R8 lane merge from array", dOut, refMem[5]);
  endtask

  task automatic tBurst();
    modeSel = 0;
    doWrite(10, 2'b00); step();
    for (int k = 0; k < 4; k++) begin
      logic [AW-1:0] a;
      a = {4'b0010, 2'(2 + k)};
      dIn = 18'h01000 + 18'(k * 18'h111);
      refMem[a] = dIn;
      if (k < 3) doAdv(2'b00);
      else begin modeSel = 1; doRead(9); end
      step();
      if (k < 3) chk("R5 write burst keeps type", {17'd0, dOe}, 18'd0);
    end
    chk("R6 interleaved beat0", dOut, refMem[9]);
    for (int j = 1; j < 5; j++) begin
      logic [AW-1:0] a;
      a = {4'b0010, 2'(2'd1 ^ 2'(j))};
      doAdv(2'b11); step();
      chk("R6 interleaved beat", dOut, refMem[a]);
      chk("R5 read burst keeps type", {17'd0, dOe}, 18'd1);
      if (j == 2) begin
        doStall(); step(); step();
        chk("R7 stall mid burst holds", dOut, refMem[a]);
      end
    end
    modeSel = 0;
    doRead(11); step();
    for (int j = 1; j < 4; j++) begin
      logic [AW-1:0] a;
      a = {4'b0010, 2'(2'd3 + 2'(j))};
      doAdv(2'b11); step();
      chk("R6 linear wrap beat", dOut, refMem[a]);
    end
    doDesel(); step();
  endtask

  task automatic doStall();
    cenN = 1;
  endtask

  task automatic tStallWrite();
    doWrite(20, 2'b00); step();
    dIn = 18'h3DEAD; doStall(); step();
    chk("R7 stalled write data cycle dOe", {17'd0, dOe}, 18'd0);
    dIn = 18'h0BEEF; doRead(20); step();
    refMem[20] = 18'h0BEEF;
    chk("R7 write takes data after stall", dOut, refMem[20]);
    doDesel(); step();
  endtask

  task automatic tDeselAdv();
    doDesel(); step();
    cenN = 0; advLd = 1; ce1N = 0; ce2 = 1; ce3N = 0; weN = 1; step();
    chk("R9 advance while deselected", {17'd0, dOe}, 18'd0);
  endtask

  task automatic tInterleave();
    doWrite(30, 2'b00); step();
    dIn = 18'h12345; doRead(5); step();
    refMem[30] = 18'h12345;
    chk("R2 read right after write data", dOut, refMem[5]);
    doWrite(31, 2'b00); step();
    chk("R4 second write data cycle", {17'd0, dOe}, 18'd0);
    dIn = 18'h2BCDE; doRead(30); step();
    refMem[31] = 18'h2BCDE;
    chk("R2 back-to-back first word", dOut, refMem[30]);
    doRead(31); step();
    chk("R2 back-to-back second word", dOut, refMem[31]);
    doDesel(); step();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    step();
    tReset();
    tSingle();
    tBytes();
    tBurst();
    tStallWrite();
    tDeselAdv();
    tInterleave();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule